// File: doc/BRIEF.md
# Interrupt priority level sampler

This block sits between an interrupt encoder and the control logic of a processor core. It takes a 3-bit active-high priority level (0 means no request) and decides when a change of that level takes effect. A change that only sets bits takes effect at the next clock edge. A change that clears any bit takes effect one edge later. For the current applied level and for the level before it, the block records the cycle at which each became active.

When the core asks for a sample, it sets one of two modes. An immediate sample takes the applied level as it is. A deferred sample takes the current level only if that level has settled long enough. Otherwise it takes the previous level if that one has settled for a shorter time. If neither has settled, it parks the current level in a second-stage register. The start of each memory cycle arms a pre-sample. If a nonzero level takes effect exactly a short delay after that start, the armed sample is repeated at that moment.

The latched level is compared with a 3-bit mask taken from a status-word write to produce the interrupt-pending flag. A mask write that lowers the mask below the applied level can also raise the flag, which is then held until the next sample.

Top module: `ipl_sampler`

## Requirements
- R1: A new input level that clears no bit of the applied level becomes the applied level at the first clock edge that sees it.
- R2: A new input level that clears at least one bit of the applied level becomes the applied level at the second clock edge that sees it. The input is not examined at the first of those two edges.
- R3: A sample strobe with smp_next_i low loads the applied level into lat_lvl_o and clears stg_lvl_o.
- R4: A sample strobe with smp_next_i high loads the current applied level if that level has been in effect for at least LONG_DLY edges, and clears stg_lvl_o.
- R5: When R4's condition fails, a deferred sample loads the previous applied level if it has been in effect for at least SHORT_DLY edges, and clears stg_lvl_o.
- R6: When neither R4 nor R5 holds, a deferred sample loads the current level into stg_lvl_o and leaves lat_lvl_o unchanged.
- R7: mcyc_i arms a pre-sample and records the mode on smp_next_i. Suppose the edge exactly SHORT_DLY edges after the arming edge applies a nonzero level. That edge then samples in the armed mode. It treats the new level as current with age 0 and the old applied level as previous, aged by the edges it was in effect. The arm expires at that edge.
- R8: irq_pend_o is high when lat_lvl_o is greater than the mask, or when the hold flag of R10 is set.
- R9: The mask comes from bits 10:8 of sr_wdata_i when sr_we_i is high. A write whose field equals the current mask changes nothing. The mask is 7 after reset.
- R10: A mask-changing write sets the hold flag when lat_lvl_o is not above the old mask and the applied level is above the new mask. Any sample, including an R7 pre-sample, clears the flag unless the flag is set at the same edge.
- R11: After reset, lat_lvl_o and stg_lvl_o are 0 and irq_pend_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ipl_i | input | 3 | Requested priority level, 0 = none |
| smp_i | input | 1 | Sample strobe |
| smp_next_i | input | 1 | Sample mode: 1 deferred, 0 immediate |
| mcyc_i | input | 1 | Memory-cycle start, arms the pre-sample |
| sr_we_i | input | 1 | Status-word write strobe |
| sr_wdata_i | input | 16 | Status word; mask in bits 10:8 |
| irq_pend_o | output | 1 | Interrupt pending |
| lat_lvl_o | output | 3 | Latched level |
| stg_lvl_o | output | 3 | Second-stage level |

## Verification
The assertions assume that reset is held low for at least one clock edge and that every input is driven to a known value at all times. The two-edge look-back on ipl_i depends on this. The stimulus drives every input from the first time step and changes inputs only on the falling clock edge. Random phases redraw ipl_i, the strobes and the status word each cycle. Directed sequences place level changes at chosen distances from samples and memory-cycle starts.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  // level pair as seen by a sample
  typedef struct packed {
    lvl_t cur;
    logic cur_long;
    lvl_t prev;
    logic prev_short;
  } view_t;
endpackage

// File: rtl/ipl_skew.sv
module ipl_skew
  import ipl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_t ipl_i,
  input  lvl_t cur_lvl_i,
  output logic apl_v_o,
  output lvl_t apl_lvl_o
);
  logic hold_v_q;
  lvl_t hold_q;
  logic diff, fall;

  assign diff = (ipl_i != cur_lvl_i);
  assign fall = |(cur_lvl_i & ~ipl_i);

  assign apl_v_o   = hold_v_q | (diff & ~fall);
  assign apl_lvl_o = hold_v_q ? hold_q : ipl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      hold_v_q <= ~hold_v_q & diff & fall;
      if (~hold_v_q & diff & fall) hold_q <= ipl_i;
    end
  end

  // R1
  rise_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_lvl_i != $past(cur_lvl_i) && ($past(cur_lvl_i) & ~cur_lvl_i) == '0)
      |-> cur_lvl_i == $past(ipl_i));
  // R2
  fall_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_lvl_i != $past(cur_lvl_i) && ($past(cur_lvl_i) & ~cur_lvl_i) != '0)
      |-> cur_lvl_i == $past(ipl_i, 2));
endmodule

// File: rtl/ipl_track.sv
module ipl_track
  import ipl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SHORT_DLY = 2,
  parameter int LONG_DLY  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apl_v_i,
  input  lvl_t             apl_lvl_i,
  input  logic             view_nxt_i,
  output lvl_t             cur_lvl_o,
  output logic [CNT_W-1:0] cyc_o,
  output view_t            view_o
);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_DLY);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_DLY);

  logic [CNT_W-1:0] cyc_q, cur_ts_q, prev_ts_q, cur_age, prev_age;
  lvl_t cur_q, prev_q;
  logic cur_old_q, prev_old_q;
  logic cur_long, prev_long;

  // wrap-safe ages; sticky bits keep a settled level settled past a wrap
  assign cur_age   = cyc_q - cur_ts_q;
  assign prev_age  = cyc_q - prev_ts_q;
  assign cur_long  = cur_old_q  | (cur_age  >= LONG_C);
  assign prev_long = prev_old_q | (prev_age >= LONG_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q      <= '0;
      cur_q      <= '0;
      prev_q     <= '0;
      cur_ts_q   <= '0;
      prev_ts_q  <= '0;
      cur_old_q  <= 1'b0;
      prev_old_q <= 1'b0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (apl_v_i) begin
        prev_q     <= cur_q;
        prev_ts_q  <= cur_ts_q;
        prev_old_q <= cur_long;
        cur_q      <= apl_lvl_i;
        cur_ts_q   <= cyc_q;
        cur_old_q  <= 1'b0;
      end else begin
        cur_old_q  <= cur_long;
        prev_old_q <= prev_long;
      end
    end
  end

  always_comb begin
    if (view_nxt_i) begin
      view_o.cur        = apl_lvl_i;
      view_o.cur_long   = 1'b0;
      view_o.prev       = cur_q;
      view_o.prev_short = cur_old_q | (cur_age >= SHORT_C);
    end else begin
      view_o.cur        = cur_q;
      view_o.cur_long   = cur_long;
      view_o.prev       = prev_q;
      view_o.prev_short = prev_old_q | (prev_age >= SHORT_C);
    end
  end

  assign cur_lvl_o = cur_q;
  assign cyc_o     = cyc_q;
endmodule

// File: rtl/ipl_grab.sv
module ipl_grab
  import ipl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SHORT_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             smp_next_i,
  input  logic             mcyc_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic             apl_v_i,
  input  lvl_t             apl_lvl_i,
  input  view_t            view_i,
  output logic             pre_hit_o,
  output logic             take_o,
  output lvl_t             lat_o,
  output lvl_t             stg_o
);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_DLY);

  logic             arm_q, arm_nxt_q;
  logic [CNT_W-1:0] arm_ts_q, arm_age;
  lvl_t             lat_q, stg_q, v_cur;
  logic             nxt_mode;

  assign arm_age   = cyc_i - arm_ts_q;
  assign pre_hit_o = arm_q & apl_v_i & (apl_lvl_i != '0) & (arm_age == SHORT_C);
  assign take_o    = smp_i | pre_hit_o;
  assign nxt_mode  = pre_hit_o ? arm_nxt_q : smp_next_i;
  assign v_cur     = view_i.cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q     <= 1'b0;
      arm_nxt_q <= 1'b0;
      arm_ts_q  <= '0;
    end else if (mcyc_i) begin
      arm_q     <= 1'b1;
      arm_nxt_q <= smp_next_i;
      arm_ts_q  <= cyc_i;
    end else if (arm_q && arm_age >= SHORT_C) begin
      arm_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      stg_q <= '0;
    end else if (take_o) begin
      if (!nxt_mode || view_i.cur_long) begin
        lat_q <= view_i.cur;
        stg_q <= '0;
      end else if (view_i.prev_short) begin
        lat_q <= view_i.prev;
        stg_q <= '0;
      end else begin
        stg_q <= view_i.cur;
      end
    end
  end

  assign lat_o = lat_q;
  assign stg_o = stg_q;

  // R3
  now_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && !smp_next_i && !pre_hit_o) |=> (lat_q == $past(v_cur) && stg_q == '0));
  // R6
  stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg_q != $past(stg_q) && stg_q != '0) |-> $stable(lat_q));
endmodule

// File: rtl/ipl_sampler.sv
module ipl_sampler
  import ipl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SHORT_DLY = 2,
  parameter int LONG_DLY  = 4,
  parameter int SR_W      = 16,
  parameter int MASK_LSB  = 8,
  parameter int MASK_RST  = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      ipl_i,
  input  logic            smp_i,
  input  logic            smp_next_i,
  input  logic            mcyc_i,
  input  logic            sr_we_i,
  input  logic [SR_W-1:0] sr_wdata_i,
  output logic            irq_pend_o,
  output logic [2:0]      lat_lvl_o,
  output logic [2:0]      stg_lvl_o
);
  logic             apl_v, pre_hit, take;
  lvl_t             apl_lvl, cur_lvl, lat, stg, mask_q, new_mask;
  logic [CNT_W-1:0] cyc;
  view_t            view;
  logic             boost_q, wr_chg, boost_set;
  logic             unused_sr;

  ipl_skew u_skew (
    .clk_i, .rst_ni, .ipl_i, .cur_lvl_i(cur_lvl),
    .apl_v_o(apl_v), .apl_lvl_o(apl_lvl)
  );

  ipl_track #(.CNT_W(CNT_W), .SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_track (
    .clk_i, .rst_ni, .apl_v_i(apl_v), .apl_lvl_i(apl_lvl), .view_nxt_i(pre_hit),
    .cur_lvl_o(cur_lvl), .cyc_o(cyc), .view_o(view)
  );

  ipl_grab #(.CNT_W(CNT_W), .SHORT_DLY(SHORT_DLY)) u_grab (
    .clk_i, .rst_ni, .smp_i, .smp_next_i, .mcyc_i, .cyc_i(cyc),
    .apl_v_i(apl_v), .apl_lvl_i(apl_lvl), .view_i(view),
    .pre_hit_o(pre_hit), .take_o(take), .lat_o(lat), .stg_o(stg)
  );

  assign unused_sr = ^sr_wdata_i;
  assign new_mask  = sr_wdata_i[MASK_LSB +: LVL_W];
  assign wr_chg    = sr_we_i & (new_mask != mask_q);
  assign boost_set = wr_chg & (lat <= mask_q) & (cur_lvl > new_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= LVL_W'(MASK_RST);
      boost_q <= 1'b0;
    end else begin
      if (wr_chg) mask_q <= new_mask;
      if (boost_set)  boost_q <= 1'b1;
      else if (take)  boost_q <= 1'b0;
    end
  end

  assign irq_pend_o = (lat > mask_q) | boost_q;
  assign lat_lvl_o  = lat;
  assign stg_lvl_o  = stg;

  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_we_i |=> $stable(mask_q));
  // R10
  boost_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boost_q) |-> $past(sr_we_i));
endmodule

// File: tb/sim_ipl_sampler.sv
module sim_ipl_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT = 2;
  localparam int LONG  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ipl = '0;
  logic        smp = 1'b0, smp_nx = 1'b0, mcyc = 1'b0, we = 1'b0;
  logic [15:0] wd = '0;
  logic        pend;
  logic [2:0]  lat, stg;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // reference state
  int m_cur, m_prev, m_cur_age, m_prev_age, m_hold_v, m_hold;
  int m_arm, m_arm_nxt, m_pre_age, m_lat, m_stg, m_mask, m_boost;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipl_sampler u0 (
    .clk_i(clk), .rst_ni(rst_n), .ipl_i(ipl), .smp_i(smp), .smp_next_i(smp_nx),
    .mcyc_i(mcyc), .sr_we_i(we), .sr_wdata_i(wd),
    .irq_pend_o(pend), .lat_lvl_o(lat), .stg_lvl_o(stg)
  );

  function automatic int f_pend(int l, int m, int b);
    return ((l > m) || (b != 0)) ? 1 : 0;
  endfunction

  function automatic int f_fall(int c, int n);
    return ((c & ~n & 7) != 0) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_prev = 0; m_cur_age = 0; m_prev_age = 0; m_hold_v = 0; m_hold = 0;
      m_arm = 0; m_arm_nxt = 0; m_pre_age = 0; m_lat = 0; m_stg = 0; m_mask = 7; m_boost = 0;
    end else begin
      int i_l, diff, fall, apl_v, apl_l, hit, vc, vlong, vp, vshort, take, mode, nl, ns, nm;
      i_l = int'(ipl);
      diff = (i_l != m_cur) ? 1 : 0;
      fall = f_fall(m_cur, i_l);
      apl_v = (m_hold_v != 0 || (diff != 0 && fall == 0)) ? 1 : 0;
      apl_l = (m_hold_v != 0) ? m_hold : i_l;
      hit = (m_arm != 0 && apl_v != 0 && apl_l != 0 && m_pre_age == SHORT) ? 1 : 0;
      if (hit != 0) begin
        vc = apl_l; vlong = 0; vp = m_cur; vshort = (m_cur_age >= SHORT) ? 1 : 0;
      end else begin
        vc = m_cur; vlong = (m_cur_age >= LONG) ? 1 : 0;
        vp = m_prev; vshort = (m_prev_age >= SHORT) ? 1 : 0;
      end
      take = (smp || hit != 0) ? 1 : 0;
      mode = (hit != 0) ? m_arm_nxt : int'(smp_nx);
      nl = m_lat; ns = m_stg;
      if (take != 0) begin
        if (mode == 0 || vlong != 0) begin nl = vc; ns = 0; end
        else if (vshort != 0) begin nl = vp; ns = 0; end
        else ns = vc;
      end
      nm = int'(wd[10:8]);
      if (we && nm != m_mask) begin
        if (m_lat <= m_mask && m_cur > nm) m_boost = 1;
        else if (take != 0) m_boost = 0;
        m_mask = nm;
      end else if (take != 0) m_boost = 0;
      m_lat = nl; m_stg = ns;
      if (mcyc) begin
        m_arm = 1; m_arm_nxt = int'(smp_nx); m_pre_age = 1;
      end else begin
        if (m_arm != 0 && m_pre_age >= SHORT) m_arm = 0;
        m_pre_age++;
      end
      if (m_hold_v == 0 && diff != 0 && fall != 0) begin m_hold_v = 1; m_hold = i_l; end
      else m_hold_v = 0;
      if (apl_v != 0) begin
        m_prev = m_cur; m_prev_age = m_cur_age + 1; m_cur = apl_l; m_cur_age = 1;
      end else begin
        m_cur_age++; m_prev_age++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R4 lat_lvl_o vs model", int'(lat), m_lat);
      chk("R6 stg_lvl_o vs model", int'(stg), m_stg);
      chk("R8 irq_pend_o vs model", int'(pend), f_pend(m_lat, m_mask, m_boost));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    smp = 1'b0; mcyc = 1'b0; we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic now_smp();
    smp = 1'b1; smp_nx = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    ticks(3);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;
    // R11 reset state
    chk("R11 lat", int'(lat), 0);
    chk("R11 stg", int'(stg), 0);
    chk("R11 pend", int'(pend), 0);

    // R1 rising change
    ipl = 3'd5; now_smp(); tick();
    chk("R1 lat before apply", int'(lat), 0);
    now_smp(); tick();
    chk("R1 lat after one edge", int'(lat), 5);

    // R2 clearing change lags by one
    ipl = 3'd4; now_smp(); tick();
    chk("R2 lat edge0", int'(lat), 5);
    now_smp(); tick();
    chk("R2 lat edge1", int'(lat), 5);
    now_smp(); tick();
    chk("R2 lat edge2", int'(lat), 4);
    ipl = 3'd6; now_smp(); tick();
    chk("R1 rise lat edge0", int'(lat), 4);
    now_smp(); tick();
    chk("R1 rise lat edge1", int'(lat), 6);

    // R7/R6 deferred pre-sample, young previous level
    ipl = 3'd0; ticks(4);
    now_smp(); tick();
    chk("R3 lat zero", int'(lat), 0);
    ipl = 3'd1; mcyc = 1'b1; smp_nx = 1'b1; tick();
    ipl = 3'd3; tick();
    ipl = 3'd7; tick();
    chk("R6 stg parked", int'(stg), 7);
    chk("R6 lat kept", int'(lat), 0);

    // R7 immediate pre-sample
    ipl = 3'd0; ticks(4);
    now_smp(); tick();
    chk("R3 stg cleared", int'(stg), 0);
    mcyc = 1'b1; smp_nx = 1'b0; tick();
    tick();
    ipl = 3'd2; tick();
    chk("R7 pre-sample hit", int'(lat), 2);
    mcyc = 1'b1; smp_nx = 1'b0; tick();
    ticks(2);
    ipl = 3'd3; tick();
    chk("R7 late apply no hit", int'(lat), 2);

    // R4/R5 stability thresholds
    ticks(5);
    now_smp(); tick();
    ipl = 3'd0; ticks(4);
    chk("R3 lat 3", int'(lat), 3);
    ipl = 3'd4; tick();
    ticks(2);
    smp = 1'b1; smp_nx = 1'b1; tick();
    chk("R5 previous taken", int'(lat), 0);
    smp = 1'b1; smp_nx = 1'b1; tick();
    chk("R4 current taken", int'(lat), 4);
    chk("R4 stg clear", int'(stg), 0);

    // R8/R9/R10 mask and hold flag
    ipl = 3'd0; ticks(4);
    now_smp(); tick();
    ipl = 3'd5; ticks(2);
    chk("R8 no pend", int'(pend), 0);
    we = 1'b1; wd = 16'h02FF; tick();
    chk("R10 hold set", int'(pend), 1);
    chk("R10 lat still 0", int'(lat), 0);
    now_smp(); tick();
    chk("R8 lat 5", int'(lat), 5);
    we = 1'b1; wd = 16'h0600; tick();
    chk("R10 hold cleared", int'(pend), 0);
    ipl = 3'd0; ticks(4);
    now_smp(); tick();
    ipl = 3'd7; ticks(2);
    we = 1'b1; wd = 16'hFEFF; tick();
    chk("R9 same field ignored", int'(pend), 0);
    we = 1'b1; wd = 16'h0100; tick();
    chk("R9 field bits 10:8", int'(pend), 1);
    now_smp(); tick();
    we = 1'b1; wd = 16'h0700; tick();
    chk("R8 mask 7 no pend", int'(pend), 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(3) == 0) ipl = 3'($urandom_range(7));
      smp    = ($urandom_range(3) == 0);
      smp_nx = ($urandom_range(1) == 1);
      mcyc   = ($urandom_range(5) == 0);
      we     = ($urandom_range(9) == 0);
      wd     = 16'($urandom);
      tick();
    end
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
  end
endmodule